// File: doc/BRIEF.md
# Branch Target Prediction Unit

This unit sits on the fetch side of a 32-bit, five-stage, in-order pipeline. In every cycle it looks up the current fetch address in a table that holds one entry per index. In the same cycle it returns a taken/not-taken guess and the address to fetch next. A taken guess therefore steers fetch with no bubble. Each entry holds a valid bit, an address tag, a 2-bit saturating confidence counter and a word-aligned target.

Control instructions flow through the same table, whether they are conditional (branch-if-equal, branch-if-not-equal) or unconditional (direct jump, jump-and-link, jump through a register). There is no separate jump path. A jump simply always resolves as taken, and its entry keeps being refreshed with the target it actually went to. This lets a register-indirect jump follow a changing destination.

When a control instruction resolves further down the pipe, the update port hands back the outcome together with the guess that was made for it. The unit corrects the entry. If the guess was wrong in direction or in target, it raises a one-cycle redirect that carries the correct next address. Decoding and target calculation are left to the rest of the pipeline.

Top module: `btPredictor`

## Requirements
- R1: A lookup uses fetch address bits [11:2] as the index and bits [31:12] as the tag. If the entry is invalid or its tag differs, `predTaken` is 0 and `predNextPc` is `fetchPc + 4`.
- R2: On a hit, `predTaken` equals bit 1 of the stored counter, so counter values 2 and 3 mean taken. `predNextPc` is the stored target (low two bits 00) when taken and `fetchPc + 4` otherwise. Both are combinational in the same cycle.
- R3: A resolution that hits its entry moves the counter up by one on a taken outcome and down by one on a not-taken outcome. The counter saturates at 3 and at 0.
- R4: A taken resolution that misses allocates the entry with its tag, a counter of 2 and the resolved target. A not-taken resolution that misses leaves the table unchanged.
- R5: A resolution with `updIsJump` = 1 is treated as taken whatever `updTaken` is. Every taken resolution rewrites the stored target with `updTarget`, so a register-indirect jump tracks its latest destination.
- R6: A misprediction exists when the actual direction differs from `updPredTaken`, or when the actual outcome is taken and `updTarget` differs from `updPredTarget`. On the clock edge that takes a valid update, `redirect` goes to 1 for exactly that mispredicting update. `redirectPc` is then `updTarget` if taken and `updPc + 4` otherwise. Otherwise `redirect` is 0.
- R7: When a lookup and an update address the same entry in the same cycle, the lookup returns the contents from before the update.
- R8: A synchronous reset (`rst` = 1 at a clock edge) clears every valid bit and the redirect output.
- R9: An entry whose tag belongs to another address at the same index counts as a miss. A taken resolution for the new address replaces it, starting again at counter 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetchPc | input | 32 | Address being fetched this cycle |
| predTaken | output | 1 | Taken guess for fetchPc |
| predNextPc | output | 32 | Guessed next fetch address |
| updValid | input | 1 | A control instruction resolves this cycle |
| updPc | input | 32 | Address of the resolving instruction |
| updIsJump | input | 1 | Resolving instruction is an unconditional jump |
| updTaken | input | 1 | Resolved direction of a conditional branch |
| updTarget | input | 32 | Resolved target address |
| updPredTaken | input | 1 | Direction that was guessed for it |
| updPredTarget | input | 32 | Next address that was guessed for it |
| redirect | output | 1 | One-cycle pulse on a misprediction |
| redirectPc | output | 32 | Correct next address while redirect is 1 |

## Verification
The lookup outputs are combinational. The bench drives each new fetch address on the falling edge and reads `predTaken` and `predNextPc` one time unit later in the same half cycle, before any edge can move them. An update changes the table on the next rising edge, and `redirect` with `redirectPc` appear after that same edge. The bench therefore reads them at the following falling edge and reads the updated entry through a lookup in the next cycle. The same-cycle lookup made while the update is pending is read before the edge and must show the old entry. A bench model of the table, built from the rules above, supplies every expected value across a sweep over two aliasing tags at eight indices with mixed branch and jump outcomes.

// File: rtl/btp_pkg.sv
package btp_pkg;

  // Strobes from the control block to the storage/datapath block
  typedef struct packed {
    logic       writeEn;     // update the addressed entry
    logic       writeTarget; // also load the target field
    logic [1:0] newCount;    // counter value to store
    logic       fireRedirect;// a misprediction was detected
    logic       useTarget;   // redirect to resolved target (else pc+4)
  } btpStrobes_t;

endpackage

// File: rtl/btpCtrl.sv
module btpCtrl
  import btp_pkg::*;
#(
  parameter int TAG_W = 20,
  parameter int PC_W  = 32
) (
  input  logic             updValid,
  input  logic             updIsJump,
  input  logic             updTaken,
  input  logic [PC_W-1:0]  updTarget,
  input  logic             updPredTaken,
  input  logic [PC_W-1:0]  updPredTarget,
  input  logic [TAG_W-1:0] updTag,
  input  logic             entValid,
  input  logic [TAG_W-1:0] entTag,
  input  logic [1:0]       entCount,
  output btpStrobes_t      strobes
);

  logic actualTaken;
  logic entHit;
  logic [1:0] stepped;
  logic wrongDir;
  logic wrongTarget;

  always_comb begin
    actualTaken = updTaken | updIsJump;
    entHit      = entValid && (entTag == updTag);

    if (actualTaken) stepped = (entCount == 2'b11) ? 2'b11 : entCount + 2'b01;
    else             stepped = (entCount == 2'b00) ? 2'b00 : entCount - 2'b01;

    wrongDir    = actualTaken != updPredTaken;
    wrongTarget = actualTaken && (updTarget != updPredTarget);

    strobes.writeEn      = updValid && (entHit || actualTaken);
    strobes.writeTarget  = actualTaken;
    strobes.newCount     = entHit ? stepped : 2'b10;
    strobes.fireRedirect = updValid && (wrongDir || wrongTarget);
    strobes.useTarget    = actualTaken;
  end

endmodule

// File: rtl/btpData.sv
module btpData
  import btp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int INDEX_W = 10,
  localparam int ENTRIES = 1 << INDEX_W,
  localparam int TAG_W   = PC_W - INDEX_W - 2,
  localparam int TGT_W   = PC_W - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PC_W-1:0]  fetchPc,
  output logic             predTaken,
  output logic [PC_W-1:0]  predNextPc,
  input  logic [PC_W-1:0]  updPc,
  input  logic [PC_W-1:0]  updTarget,
  output logic [TAG_W-1:0] updTag,
  output logic             entValid,
  output logic [TAG_W-1:0] entTag,
  output logic [1:0]       entCount,
  input  btpStrobes_t      strobes,
  output logic             redirect,
  output logic [PC_W-1:0]  redirectPc
);

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ   [ENTRIES];
  logic [1:0]         countQ [ENTRIES];
  logic [TGT_W-1:0]   targetQ[ENTRIES];

  logic [INDEX_W-1:0] lookIdx;
  logic [TAG_W-1:0]   lookTag;
  logic [INDEX_W-1:0] updIdx;
  logic               lookHit;

  assign lookIdx = fetchPc[INDEX_W+1:2];
  assign lookTag = fetchPc[PC_W-1:INDEX_W+2];
  assign updIdx  = updPc[INDEX_W+1:2];
  assign updTag  = updPc[PC_W-1:INDEX_W+2];

  // Lookup: reads the stored state, so a same-cycle write is not visible
  always_comb begin
    lookHit    = validQ[lookIdx] && (tagQ[lookIdx] == lookTag);
    predTaken  = lookHit && countQ[lookIdx][1];
    predNextPc = predTaken ? {targetQ[lookIdx], 2'b00} : fetchPc + PC_W'(4);
  end

  // Update-side read for the control block
  assign entValid = validQ[updIdx];
  assign entTag   = tagQ[updIdx];
  assign entCount = countQ[updIdx];

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
    end else if (strobes.writeEn) begin
      validQ[updIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && strobes.writeEn) begin
      tagQ[updIdx]   <= updTag;
      countQ[updIdx] <= strobes.newCount;
      if (strobes.writeTarget) targetQ[updIdx] <= updTarget[PC_W-1:2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect   <= 1'b0;
      redirectPc <= '0;
    end else begin
      redirect   <= strobes.fireRedirect;
      redirectPc <= strobes.useTarget ? updTarget : updPc + PC_W'(4);
    end
  end

endmodule

// File: rtl/btPredictor.sv
module btPredictor
  import btp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int INDEX_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetchPc,
  output logic            predTaken,
  output logic [PC_W-1:0] predNextPc,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updIsJump,
  input  logic            updTaken,
  input  logic [PC_W-1:0] updTarget,
  input  logic            updPredTaken,
  input  logic [PC_W-1:0] updPredTarget,
  output logic            redirect,
  output logic [PC_W-1:0] redirectPc
);

  localparam int TAG_W = PC_W - INDEX_W - 2;

  btpStrobes_t      strobes;
  logic [TAG_W-1:0] updTag;
  logic             entValid;
  logic [TAG_W-1:0] entTag;
  logic [1:0]       entCount;

  btpCtrl #(.TAG_W(TAG_W), .PC_W(PC_W)) ctrl (
    .updValid(updValid), .updIsJump(updIsJump), .updTaken(updTaken),
    .updTarget(updTarget), .updPredTaken(updPredTaken),
    .updPredTarget(updPredTarget), .updTag(updTag),
    .entValid(entValid), .entTag(entTag), .entCount(entCount),
    .strobes(strobes)
  );

  btpData #(.PC_W(PC_W), .INDEX_W(INDEX_W)) data (
    .clk(clk), .rst(rst), .fetchPc(fetchPc),
    .predTaken(predTaken), .predNextPc(predNextPc),
    .updPc(updPc), .updTarget(updTarget), .updTag(updTag),
    .entValid(entValid), .entTag(entTag), .entCount(entCount),
    .strobes(strobes), .redirect(redirect), .redirectPc(redirectPc)
  );

endmodule

// File: rtl/btPredictorChecker.sv
module btPredictorChecker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] fetchPc,
  input logic            predTaken,
  input logic [PC_W-1:0] predNextPc,
  input logic            updValid,
  input logic [PC_W-1:0] updPc,
  input logic            updIsJump,
  input logic            updTaken,
  input logic [PC_W-1:0] updTarget,
  input logic            updPredTaken,
  input logic [PC_W-1:0] updPredTarget,
  input logic            redirect,
  input logic [PC_W-1:0] redirectPc
);

  // R1, R2: a not-taken guess always falls through
  p_fallthrough_r1: assert property (@(posedge clk) disable iff (rst)
    !predTaken |-> predNextPc == fetchPc + PC_W'(4));

  // R2: a taken guess comes from a stored word-aligned target
  p_aligned_target_r2: assert property (@(posedge clk) disable iff (rst)
    predTaken |-> predNextPc[1:0] == 2'b00);

  // R6: no redirect without an update in the cycle before
  p_redirect_cause_r6: assert property (@(posedge clk) disable iff (rst)
    redirect |-> $past(updValid));

  // R6: a not-taken misprediction redirects to the fall-through address
  p_redirect_fall_r6: assert property (@(posedge clk) disable iff (rst)
    (redirect && !$past(updTaken) && !$past(updIsJump)) |-> redirectPc == $past(updPc) + PC_W'(4));

  // R5, R6: a correctly guessed jump never redirects
  p_jump_correct_r5: assert property (@(posedge clk) disable iff (rst)
    (updValid && updIsJump && updPredTaken && updTarget == updPredTarget) |=> !redirect);

  // R8: right after reset nothing is predicted taken
  p_reset_clears_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !predTaken);

endmodule

bind btPredictor btPredictorChecker #(.PC_W(PC_W)) chk (.*);

// File: tb/btPredictor_test.sv
module btPredictor_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] fetchPc;
  logic        predTaken;
  logic [31:0] predNextPc;
  logic        updValid;
  logic [31:0] updPc;
  logic        updIsJump;
  logic        updTaken;
  logic [31:0] updTarget;
  logic        updPredTaken;
  logic [31:0] updPredTarget;
  logic        redirect;
  logic [31:0] redirectPc;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  btPredictor uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench model of the table
  bit        mValid [1024];
  bit [19:0] mTag   [1024];
  bit [1:0]  mCnt   [1024];
  bit [31:0] mTgt   [1024];

  function automatic void modelLook(input bit [31:0] pc, output bit tk, output bit [31:0] nx);
    int i = int'(pc[11:2]);
    bit hit = mValid[i] && mTag[i] == pc[31:12];
    tk = hit && mCnt[i] >= 2;
    nx = tk ? mTgt[i] : pc + 32'd4;
  endfunction

  function automatic void modelUpdate(input bit [31:0] pc, input bit act, input bit [31:0] tgt);
    int i = int'(pc[11:2]);
    bit hit = mValid[i] && mTag[i] == pc[31:12];
    if (hit) begin
      if (act) mCnt[i] = (mCnt[i] == 3) ? 2'd3 : mCnt[i] + 2'd1;
      else     mCnt[i] = (mCnt[i] == 0) ? 2'd0 : mCnt[i] - 2'd1;
      if (act) mTgt[i] = tgt;
    end else if (act) begin
      mValid[i] = 1; mTag[i] = pc[31:12]; mCnt[i] = 2; mTgt[i] = tgt;
    end
  endfunction

  task automatic check(input string req, input bit [63:0] act, input bit [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Lookup at the falling edge, check combinational outputs
  task automatic lookCheck(input bit [31:0] pc, input string req);
    bit tk; bit [31:0] nx;
    @(negedge clk);
    fetchPc = pc;
    #1;
    modelLook(pc, tk, nx);
    check(req, {31'd0, predTaken, predNextPc}, {31'd0, tk, nx});
  endtask

  // One update; same-cycle lookup of the same pc (R7), then redirect check (R6)
  task automatic doUpdate(input bit [31:0] pc, input bit jmp, input bit tkn,
                          input bit [31:0] tgt, input bit pTk, input bit [31:0] pTgt);
    bit act; bit mis; bit [31:0] rpc; bit tk; bit [31:0] nx;
    @(negedge clk);
    updValid = 1; updPc = pc; updIsJump = jmp; updTaken = tkn;
    updTarget = tgt; updPredTaken = pTk; updPredTarget = pTgt;
    fetchPc = pc;
    #1;
    modelLook(pc, tk, nx);
    check("R7 same-cycle lookup sees old entry", {31'd0, predTaken, predNextPc}, {31'd0, tk, nx});
    act = tkn | jmp;
    mis = (act != pTk) || (act && tgt != pTgt);
    rpc = act ? tgt : pc + 32'd4;
    modelUpdate(pc, act, tgt);
    @(negedge clk);
    updValid = 0;
    check("R6 redirect flag", {63'd0, redirect}, {63'd0, mis});
    if (mis) check("R6 redirect address", {32'd0, redirectPc}, {32'd0, rpc});
  endtask

  function automatic bit [31:0] mkPc(input int tagSel, input int idx);
    return {(tagSel != 0) ? 20'h00020 : 20'h00010, idx[9:0], 2'b00};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit [31:0] lfsr = 32'h1ACE_B00C;
    bit tk; bit [31:0] nx;
    rst = 1; fetchPc = 0; updValid = 0; updPc = 0; updIsJump = 0; updTaken = 0;
    updTarget = 0; updPredTaken = 0; updPredTarget = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: after reset every lookup misses
    for (int i = 0; i < 8; i++) lookCheck(mkPc(i % 2, i), "R1 miss after reset");
    check("R8 redirect clear after reset", {63'd0, redirect}, 64'd0);

    // R4: not-taken miss leaves table empty, then taken miss allocates at 2
    doUpdate(mkPc(0, 3), 0, 0, 32'h0000_4000, 0, mkPc(0, 3) + 4);
    lookCheck(mkPc(0, 3), "R4 not-taken miss no allocation");
    doUpdate(mkPc(0, 3), 0, 1, 32'h0000_4000, 0, mkPc(0, 3) + 4);
    lookCheck(mkPc(0, 3), "R4 taken miss allocates weakly taken");
    check("R4 allocated target", {32'd0, predNextPc}, 64'h4000);

    // R3: saturate up, then walk down to 0 and stay
    for (int k = 0; k < 3; k++) doUpdate(mkPc(0, 3), 0, 1, 32'h0000_4000, 1, 32'h0000_4000);
    doUpdate(mkPc(0, 3), 0, 0, 32'h0000_4000, 1, 32'h0000_4000);
    lookCheck(mkPc(0, 3), "R3 saturated at 3 then 2 still taken");
    check("R3 still taken after one decrement", {63'd0, predTaken}, 64'd1);
    for (int k = 0; k < 4; k++) doUpdate(mkPc(0, 3), 0, 0, 32'h0000_4000, 0, mkPc(0, 3) + 4);
    doUpdate(mkPc(0, 3), 0, 1, 32'h0000_4000, 0, mkPc(0, 3) + 4);
    lookCheck(mkPc(0, 3), "R3 floor at 0 then 1 not taken");
    check("R3 counter 1 predicts not taken", {63'd0, predTaken}, 64'd0);

    // R5: register-indirect jump with updTaken=0 and a moving target
    doUpdate(mkPc(0, 5), 1, 0, 32'h0000_8000, 0, mkPc(0, 5) + 4);
    lookCheck(mkPc(0, 5), "R5 jump allocates as taken");
    doUpdate(mkPc(0, 5), 1, 0, 32'h0000_9000, 1, 32'h0000_8000);
    lookCheck(mkPc(0, 5), "R5 jump target refreshed");
    check("R5 new jump target", {32'd0, predNextPc}, 64'h9000);

    // R9: alias at same index with another tag
    lookCheck(mkPc(1, 5), "R9 alias tag misses");
    doUpdate(mkPc(1, 5), 0, 1, 32'h0000_A000, 0, mkPc(1, 5) + 4);
    lookCheck(mkPc(0, 5), "R9 old owner evicted");
    lookCheck(mkPc(1, 5), "R9 new owner at counter 2");

    // Sweep: mixed outcomes over 8 indices x 2 tags; predictions from model
    for (int n = 0; n < 600; n++) begin
      bit [31:0] pc; bit jmp; bit tkn; bit [31:0] tgt;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      pc  = mkPc(int'(lfsr[3]), int'(lfsr[6:4]));
      jmp = lfsr[9:8] == 2'b00;
      tkn = lfsr[10] | lfsr[11];
      tgt = {16'h0001, 10'd0, lfsr[14:12], 3'b000};
      modelLook(pc, tk, nx);
      doUpdate(pc, jmp, tkn, tgt, tk, nx);
      lookCheck(pc, "R2 R3 sweep lookup");
    end

    // R8: synchronous reset clears all entries
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int i = 0; i < 1024; i++) mValid[i] = 0;
    for (int i = 0; i < 8; i++) begin
      lookCheck(mkPc(0, i), "R8 cleared by reset");
      lookCheck(mkPc(1, i), "R8 cleared by reset");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule